// File: doc/BRIEF.md
# Protection Region Bound Decoder

This block turns one protection entry's matching mode, its address register and the address register of the entry just below it into an explicit, inclusive byte range. The result is a start address, an end address and a flag that says whether the range can match anything. A downstream comparator can then test an access address with two magnitude compares and no further decoding. Address registers carry byte address bits [XLEN+1:2], so both bounds are XLEN+2 bits wide.

The decoded bounds sit in registers. They are reloaded on a single-cycle refresh strobe, which the surrounding logic raises whenever the entry's mode or either address register is written. One copy is placed per entry. The lowest entry ties its first-entry input high, so its top-of-range mode starts from byte zero.

Top module: `rgn_bound_dec`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs become `lo_o` = 0, `hi_o` = 0 and `valid_o` = 0.
- R2: When `upd_i` is high at a rising edge, the outputs show the decode of that edge's inputs from that edge onward. While `upd_i` is low, the outputs keep their values no matter how the other inputs move.
- R3: Mode code 2'b00 (disabled) gives `valid_o` = 0, `lo_o` = 0 and `hi_o` = 0.
- R4: Mode code 2'b01 (top of range) gives `lo_o` = {P, 2'b00} and `hi_o` = {`addr_i`, 2'b00} − 1, modulo 2^(XLEN+2). P is the lower address.
- R5: In top-of-range mode with `first_i` = 1, P is zero and `prev_addr_i` is ignored. With `first_i` = 0, P is `prev_addr_i`.
- R6: In top-of-range mode, `valid_o` = 1 exactly when `addr_i` > P. An empty or inverted range reports 0.
- R7: Mode code 2'b10 (naturally aligned 4-byte) gives `lo_o` = {`addr_i`, 2'b00}, `hi_o` = `lo_o` + 3 and `valid_o` = 1.
- R8: Mode code 2'b11 (naturally aligned power of two) uses t, the number of consecutive ones at the low end of `addr_i`. It gives `lo_o` = {`addr_i` with bits [t-1:0] cleared, 2'b00}, `hi_o` = `lo_o` + 2^(t+3) − 1 and `valid_o` = 1. A low bit of 0 means 8 bytes, 01 means 16 bytes, 011 means 32 bytes, and so on.
- R9: In power-of-two mode with `addr_i` all ones, the range is the whole space: `lo_o` = 0 and `hi_o` = all ones.
- R10: In modes 2'b00, 2'b10 and 2'b11, `prev_addr_i` and `first_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Refresh strobe: load the decode of the current inputs |
| mode_i | input | 2 | Matching mode: 00 disabled, 01 top of range, 10 aligned 4-byte, 11 aligned power of two |
| addr_i | input | XLEN | This entry's address register (byte bits [XLEN+1:2]) |
| prev_addr_i | input | XLEN | Address register of the entry below |
| first_i | input | 1 | High for the lowest entry, which has no entry below |
| lo_o | output | XLEN+2 | Inclusive start byte address |
| hi_o | output | XLEN+2 | Inclusive end byte address |
| valid_o | output | 1 | Range can match |

## Verification
The bench targets the trailing-ones count at its ends, using zero, single-one, 31-ones and all-ones registers. An off-by-one encoder halves or doubles the region there, and a wrong all-ones case wraps the end below the start. Top-of-range is driven with a zero address, with equal bounds and with a lower entry that holds garbage while `first_i` is high. A design that forgets the wrap, or reads the lower entry for the first entry, reports a bogus start or a valid empty range. Stray values on the unused inputs and input changes without a strobe expose decoders that leak the previous address into other modes or that fail to hold their registers.

// File: rtl/rgn_bound_pkg.sv
package rgn_bound_pkg;
  typedef enum logic [1:0] {
    RGN_OFF   = 2'b00,
    RGN_TOR   = 2'b01,
    RGN_WORD  = 2'b10,
    RGN_POW2  = 2'b11
  } rgn_mode_e;
endpackage

// File: rtl/trail_ones_enc.sv
// Priority encoder: index of the lowest zero bit (W when none), plus a
// mask covering every bit at or below that index.
module trail_ones_enc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o,
  output logic [W-1:0]  mask_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!vec_i[i]) cnt_o = CW'(i);
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask_o[g] = (CW'(g) <= cnt_o);
  end
endmodule

// File: rtl/pow2_span.sv
// Aligned power-of-two range from a trailing-ones size code.
module pow2_span #(
  parameter int XLEN = 32,
  localparam int BW = XLEN + 2,
  localparam int CW = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0] addr_i,
  output logic [BW-1:0]   lo_o,
  output logic [BW-1:0]   hi_o
);
  logic [CW-1:0]   ones_cnt;
  logic [XLEN-1:0] low_mask;

  trail_ones_enc #(.W(XLEN)) u_enc (
    .vec_i  (addr_i),
    .cnt_o  (ones_cnt),
    .mask_o (low_mask)
  );

  // Bit t of addr is zero, so clearing through t equals clearing below t,
  // and base + size - 1 is base with every masked bit set.
  assign lo_o = {addr_i & ~low_mask, 2'b00};
  assign hi_o = {addr_i | low_mask, 2'b11};
endmodule

// File: rtl/tor_span.sv
// Top-of-range bounds from this entry's and the lower entry's registers.
module tor_span #(
  parameter int XLEN = 32,
  localparam int BW = XLEN + 2
) (
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] prev_addr_i,
  input  logic            first_i,
  output logic [BW-1:0]   lo_o,
  output logic [BW-1:0]   hi_o,
  output logic            nonempty_o
);
  logic [XLEN-1:0] base;

  assign base       = first_i ? '0 : prev_addr_i;
  assign lo_o       = {base, 2'b00};
  assign hi_o       = {addr_i, 2'b00} - BW'(1);
  assign nonempty_o = (addr_i > base);
endmodule

// File: rtl/rgn_bound_dec.sv
module rgn_bound_dec
  import rgn_bound_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int BW = XLEN + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_i,
  input  logic [1:0]      mode_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] prev_addr_i,
  input  logic            first_i,
  output logic [BW-1:0]   lo_o,
  output logic [BW-1:0]   hi_o,
  output logic            valid_o
);
  rgn_mode_e mode;
  assign mode = rgn_mode_e'(mode_i);

  logic [BW-1:0] tor_lo, tor_hi, p2_lo, p2_hi;
  logic          tor_ok;

  tor_span #(.XLEN(XLEN)) u_tor (
    .addr_i      (addr_i),
    .prev_addr_i (prev_addr_i),
    .first_i     (first_i),
    .lo_o        (tor_lo),
    .hi_o        (tor_hi),
    .nonempty_o  (tor_ok)
  );

  pow2_span #(.XLEN(XLEN)) u_p2 (
    .addr_i (addr_i),
    .lo_o   (p2_lo),
    .hi_o   (p2_hi)
  );

  logic [BW-1:0] nx_lo, nx_hi;
  logic          nx_valid;

  always_comb begin
    nx_lo    = '0;
    nx_hi    = '0;
    nx_valid = 1'b0;
    unique case (mode)
      RGN_TOR: begin
        nx_lo    = tor_lo;
        nx_hi    = tor_hi;
        nx_valid = tor_ok;
      end
      RGN_WORD: begin
        nx_lo    = {addr_i, 2'b00};
        nx_hi    = {addr_i, 2'b11};
        nx_valid = 1'b1;
      end
      RGN_POW2: begin
        nx_lo    = p2_lo;
        nx_hi    = p2_hi;
        nx_valid = 1'b1;
      end
      default: begin
        nx_lo    = '0;
        nx_hi    = '0;
        nx_valid = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_o    <= '0;
      hi_o    <= '0;
      valid_o <= 1'b0;
    end else if (upd_i) begin
      lo_o    <= nx_lo;
      hi_o    <= nx_hi;
      valid_o <= nx_valid;
    end
  end

  logic [BW-1:0] span;
  assign span = hi_o - lo_o;

  AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> ($stable(lo_o) && $stable(hi_o) && $stable(valid_o))); // R2
  AST_OFF_NEVER_VALID: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 2'b00) |=> !valid_o); // R3
  AST_TOR_START: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 2'b01 && !first_i) |=> lo_o == {$past(prev_addr_i), 2'b00}); // R4
  AST_TOR_FIRST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 2'b01 && first_i) |=> lo_o == '0); // R5
  AST_WORD_SPAN: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 2'b10) |=> (valid_o && span == BW'(3))); // R7
  AST_POW2_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 2'b11) |=> (((span & (span + BW'(1))) == '0) && ((lo_o & span) == '0))); // R8
  AST_POW2_MIN8: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 2'b11) |=> span >= BW'(7)); // R8
endmodule

// File: tb/tb_rgn_bound_dec.sv
`timescale 1ns/1ps
module tb_rgn_bound_dec;
  localparam int XLEN = 32;
  localparam int BW = XLEN + 2;

  logic            clk = 1'b0;
  logic            rst;
  logic            upd_i;
  logic [1:0]      mode_i;
  logic [XLEN-1:0] addr_i;
  logic [XLEN-1:0] prev_addr_i;
  logic            first_i;
  logic [BW-1:0]   lo_o, hi_o;
  logic            valid_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rgn_bound_dec #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .upd_i(upd_i), .mode_i(mode_i), .addr_i(addr_i),
    .prev_addr_i(prev_addr_i), .first_i(first_i),
    .lo_o(lo_o), .hi_o(hi_o), .valid_o(valid_o)
  );

  function automatic void model(input logic [1:0] m, input logic [XLEN-1:0] a,
                                input logic [XLEN-1:0] p, input logic f,
                                output logic [BW-1:0] s, output logic [BW-1:0] e,
                                output logic v);
    logic [XLEN-1:0] pp;
    int t;
    s = '0; e = '0; v = 1'b0;
    case (m)
      2'b01: begin
        pp = f ? '0 : p;
        s = {pp, 2'b00};
        e = {a, 2'b00} - BW'(1);
        v = (a > pp);
      end
      2'b10: begin
        s = {a, 2'b00};
        e = s + BW'(3);
        v = 1'b1;
      end
      2'b11: begin
        t = 0;
        while (t < XLEN && a[t]) t++;
        s = (({2'b00, a} >> t) << t) << 2;
        e = s + ((BW'(1) << (t + 3)) - BW'(1));
        v = 1'b1;
      end
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input logic [BW-1:0] s, input logic [BW-1:0] e,
                       input logic v);
    tests++;
    if (lo_o !== s || hi_o !== e || valid_o !== v) begin
      fails++;
      $display("FAIL %s: got lo=%h hi=%h v=%b expected lo=%h hi=%h v=%b",
               req, lo_o, hi_o, valid_o, s, e, v);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] m, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] p, input logic f);
    logic [BW-1:0] s, e;
    logic v;
    @(negedge clk);
    mode_i = m; addr_i = a; prev_addr_i = p; first_i = f; upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
    model(m, a, p, f, s, e, v);
    check(req, s, e, v);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] hs, he;
    logic hv;
    void'($urandom(1234));
    rst = 1'b1; upd_i = 1'b0; mode_i = 2'b00; addr_i = '0; prev_addr_i = '0; first_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, '0, 1'b0);
    rst = 1'b0;

    // R3 disabled
    apply("R3 off", 2'b00, 32'h1234_5678, 32'h0000_0010, 1'b0);
    // R4 top of range
    apply("R4 tor", 2'b01, 32'h0000_0400, 32'h0000_0100, 1'b0);
    apply("R4 tor wrap zero", 2'b01, 32'h0, 32'h0, 1'b0);
    // R5 first entry ignores lower register
    apply("R5 tor first", 2'b01, 32'h0000_0040, 32'hFFFF_0000, 1'b1);
    // R6 empty and inverted
    apply("R6 tor equal", 2'b01, 32'h0000_0200, 32'h0000_0200, 1'b0);
    apply("R6 tor inverted", 2'b01, 32'h0000_0100, 32'h0000_0200, 1'b0);
    // R7 word
    apply("R7 word", 2'b10, 32'hFFFF_FFFF, 32'h0, 1'b0);
    apply("R7 word low", 2'b10, 32'h0, 32'h0, 1'b0);
    // R8 power of two size codes
    apply("R8 pow2 8B", 2'b11, 32'h0000_1000, 32'h0, 1'b0);
    apply("R8 pow2 16B", 2'b11, 32'h0000_1001, 32'h0, 1'b0);
    apply("R8 pow2 32B", 2'b11, 32'h0000_1003, 32'h0, 1'b0);
    apply("R8 pow2 31 ones", 2'b11, 32'h7FFF_FFFF, 32'h0, 1'b0);
    apply("R8 pow2 top bit", 2'b11, 32'hBFFF_FFFF, 32'h0, 1'b0);
    // R9 whole space
    apply("R9 pow2 all ones", 2'b11, 32'hFFFF_FFFF, 32'h0, 1'b0);
    // R10 lower register and first flag ignored outside top of range
    apply("R10 pow2 stray prev", 2'b11, 32'h0000_100F, 32'hDEAD_BEEF, 1'b1);
    apply("R10 word stray prev", 2'b10, 32'h0000_0ABC, 32'h1234_5678, 1'b1);
    apply("R10 off stray prev", 2'b00, 32'h0000_0ABC, 32'hFFFF_FFFF, 1'b1);

    // R2 hold without strobe
    apply("R2 load", 2'b10, 32'h0000_0300, 32'h0, 1'b0);
    model(2'b10, 32'h0000_0300, 32'h0, 1'b0, hs, he, hv);
    @(negedge clk);
    mode_i = 2'b11; addr_i = 32'h5555_0000; prev_addr_i = 32'h1; first_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 hold", hs, he, hv);

    // Random mix with biased trailing ones
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      logic [XLEN-1:0] a, p;
      int k;
      m = 2'($urandom);
      a = $urandom;
      p = $urandom;
      if ($urandom % 2 == 0) begin
        k = $urandom % (XLEN + 1);
        a = (k == XLEN) ? '1 : ((a & ~((XLEN'(1) << (k + 1)) - 1)) | ((XLEN'(1) << k) - 1));
      end
      if ($urandom % 3 == 0) p = a - XLEN'($urandom % 3);
      apply("R2 random decode", m, a, p, 1'($urandom));
    end

    // R1 reset after activity
    apply("R7 before reset", 2'b10, 32'h0000_0044, 32'h0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", '0, '0, 1'b0);
    rst = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule